// File: doc/BRIEF.md
# Mesh Event Tape Sequencer

The sequencer walks a flat list of collective-communication events held in a local table, one entry per event, strictly in index order. For each event it asks an external compare unit whether a named semaphore has reached the entry's wait value, and repeats the request until the answer is yes. Once the gate opens it issues the event's broadcast doorbell writes (at most two), then its increment writes toward neighbour semaphores (at most three), all through one register write master. After the last write of an event it moves to the next index. When the index reaches the programmed count it pulses done and returns to idle.

Software, or a higher-level controller, fills the table, sets the semaphores and pulses start together with an event count. The table read port has a fixed latency of one cycle. The compare port and the write master both use a request/acknowledge handshake, so either side may stall. The parameter `FULL_TAPE` selects the tape depth: 108 events when set, 50 when cleared.

The controller has eight states, named here with their transitions:
- IDLE goes to FETCH on start, or straight to DONE when the clamped count is zero.
- FETCH issues the table read and always goes to LOAD.
- LOAD captures the entry and always goes to WAIT.
- WAIT holds the compare request. It goes to BCAST, INC or NEXT on an acknowledge that reports greater-or-equal, and stays in WAIT on an acknowledge that reports less.
- BCAST steps through its slots and leaves after the final accepted write, to INC or NEXT.
- INC steps through its slots and leaves to NEXT after the final accepted write.
- NEXT advances the index and goes to DONE after the last event, otherwise to FETCH.
- DONE returns to IDLE.

Top module: `mesh_tape_seq`

## Requirements
- R1: After reset, busy_o, done_o, tbl_rd_en_o, cmp_req_o and wr_valid_o are all low, and they stay low until a start is taken.
- R2: A table word packs its fields from the least significant bit upward, in this order:
  - semaphore index (SEM_W bits)
  - wait value (VAL_W bits)
  - broadcast count (2 bits)
  - increment count (2 bits)
  - broadcast addresses for slots 0 and 1 (ADDR_W bits each)
  - engine bitmaps for slots 0 and 1 (BMP_W bits each)
  - increment addresses for slots 0 to 2 (ADDR_W bits each)

  On a start with count N, the block reads table addresses 0 to N-1 in increasing order, once each. Every write of an event is accepted before the next event's table read.
- R3: No write of an event is issued until a compare acknowledge reports greater-or-equal. The compare request carries the entry's semaphore index and wait value. An acknowledge that reports less causes the request to be repeated.
- R4: Broadcast writes go to the broadcast slot addresses in slot order 0 then 1. Each carries the data (bitmap << 16) | 0x100 built from that slot's engine bitmap. A broadcast count of 3 is treated as 2.
- R5: Increment writes follow the broadcast writes. They go to the increment slot addresses in slot order 0, 1, 2, each with data 1.
- R6: A broadcast count or an increment count of zero skips that phase entirely. An event with both counts zero issues no writes.
- R7: done_o is high for exactly one cycle after the last write of the last event is accepted, and busy_o is low in the following cycle. A count of 0 produces the done pulse with no table read.
- R8: A count above the tape depth (108 with FULL_TAPE=1, 50 with FULL_TAPE=0) is clamped to the tape depth.
- R9: A start request while busy_o is high is ignored: the running tape is not restarted, extended or shortened.
- R10: While a write or a compare request is waiting for its acknowledge, its valid/request stays high and its address, data, semaphore index and wait value stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| count_i | input | IDX_W | Number of events to run |
| busy_o | output | 1 | High from the cycle after start until done |
| done_o | output | 1 | One-cycle completion pulse |
| tbl_rd_en_o | output | 1 | Table read strobe |
| tbl_rd_addr_o | output | IDX_W | Event index being read |
| tbl_rd_data_i | input | ENTRY_W | Table word, valid one cycle after the strobe |
| cmp_req_o | output | 1 | Semaphore compare request |
| cmp_sem_o | output | SEM_W | Semaphore index to compare |
| cmp_val_o | output | VAL_W | Wait value to compare against |
| cmp_ack_i | input | 1 | Compare answer valid |
| cmp_ge_i | input | 1 | Semaphore is greater than or equal to the wait value |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | VAL_W | Write data |
| wr_ready_i | input | 1 | Write accepted in this cycle |

## Verification
The bench builds the block with FULL_TAPE=0, so the tape depth is 50. At that depth, clamping a count of 60 takes only a few hundred cycles. Widths stay at their defaults (16-bit index, 8-bit semaphore index, 32-bit values and addresses), so the doorbell data layout and the table packing are exercised exactly as specified. Toggling write readiness and a compare responder that answers "less" until the bench raises the semaphore bring both handshake stalls and the wait-gating retry loop within reach.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int BC_SLOTS      = 2;
    localparam int INC_SLOTS     = 3;
    localparam int CNT_W         = 2;
    localparam int SLOT_W        = 2;
    localparam int DB_SHIFT      = 16;
    localparam int DB_FLAG       = 256;
    localparam int INC_STEP      = 1;
    localparam int FULL_DEPTH    = 108;
    localparam int REDUCED_DEPTH = 50;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_WAIT,
        S_BCAST,
        S_INC,
        S_NEXT,
        S_DONE
    } mts_state_e;

endpackage

// File: rtl/mts_entry_reg.sv
module mts_entry_reg
    import mts_pkg::*;
#(
    parameter int SEM_W   = 8,
    parameter int VAL_W   = 32,
    parameter int BMP_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int ENTRY_W = 236
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load_i,
    input  logic [ENTRY_W-1:0]                   entry_i,
    output logic [SEM_W-1:0]                     sem_o,
    output logic [VAL_W-1:0]                     wait_o,
    output logic [CNT_W-1:0]                     nb_o,
    output logic [CNT_W-1:0]                     ni_o,
    output logic [BC_SLOTS-1:0][ADDR_W-1:0]      bc_addr_o,
    output logic [BC_SLOTS-1:0][BMP_W-1:0]       bc_map_o,
    output logic [INC_SLOTS-1:0][ADDR_W-1:0]     inc_addr_o
);

    localparam int O_SEM  = 0;
    localparam int O_WAIT = O_SEM + SEM_W;
    localparam int O_NB   = O_WAIT + VAL_W;
    localparam int O_NI   = O_NB + CNT_W;
    localparam int O_BA   = O_NI + CNT_W;
    localparam int O_BM   = O_BA + BC_SLOTS * ADDR_W;
    localparam int O_IA   = O_BM + BC_SLOTS * BMP_W;

    logic [ENTRY_W-1:0] ent_q;
    logic [CNT_W-1:0]   nb_raw;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else if (load_i) begin
            ent_q <= entry_i;
        end
    end

    assign sem_o  = ent_q[O_SEM  +: SEM_W];
    assign wait_o = ent_q[O_WAIT +: VAL_W];
    assign nb_raw = ent_q[O_NB   +: CNT_W];
    assign ni_o   = ent_q[O_NI   +: CNT_W];

    // A broadcast count beyond the slot count saturates at the slot count.
    assign nb_o = (nb_raw > CNT_W'(BC_SLOTS)) ? CNT_W'(BC_SLOTS) : nb_raw;

    for (genvar s = 0; s < BC_SLOTS; s++) begin : g_bc
        assign bc_addr_o[s] = ent_q[O_BA + s * ADDR_W +: ADDR_W];
        assign bc_map_o[s]  = ent_q[O_BM + s * BMP_W  +: BMP_W];
    end

    for (genvar s = 0; s < INC_SLOTS; s++) begin : g_inc
        assign inc_addr_o[s] = ent_q[O_IA + s * ADDR_W +: ADDR_W];
    end

endmodule

// File: rtl/mts_write_mux.sv
module mts_write_mux
    import mts_pkg::*;
#(
    parameter int VAL_W  = 32,
    parameter int BMP_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                             bcast_i,
    input  logic                             inc_i,
    input  logic [SLOT_W-1:0]                slot_i,
    input  logic [BC_SLOTS-1:0][ADDR_W-1:0]  bc_addr_i,
    input  logic [BC_SLOTS-1:0][BMP_W-1:0]   bc_map_i,
    input  logic [INC_SLOTS-1:0][ADDR_W-1:0] inc_addr_i,
    output logic [ADDR_W-1:0]                addr_o,
    output logic [VAL_W-1:0]                 data_o
);

    logic [BC_SLOTS-1:0][VAL_W-1:0] db_word;

    // Doorbell word per broadcast slot: engine bitmap in the upper half, trigger flag below.
    for (genvar s = 0; s < BC_SLOTS; s++) begin : g_db
        assign db_word[s] = (VAL_W'(bc_map_i[s]) << DB_SHIFT) | VAL_W'(DB_FLAG);
    end

    always_comb begin
        addr_o = '0;
        data_o = '0;
        if (bcast_i) begin
            for (int s = 0; s < BC_SLOTS; s++) begin
                if (slot_i == SLOT_W'(s)) begin
                    addr_o = bc_addr_i[s];
                    data_o = db_word[s];
                end
            end
        end else if (inc_i) begin
            for (int s = 0; s < INC_SLOTS; s++) begin
                if (slot_i == SLOT_W'(s)) begin
                    addr_o = inc_addr_i[s];
                    data_o = VAL_W'(INC_STEP);
                end
            end
        end
    end

endmodule

// File: rtl/mts_fsm.sv
module mts_fsm
    import mts_pkg::*;
#(
    parameter int IDX_W      = 16,
    parameter int MAX_EVENTS = 108
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  count_i,
    input  logic              cmp_ack_i,
    input  logic              cmp_ge_i,
    input  logic              wr_ready_i,
    input  logic [CNT_W-1:0]  nb_i,
    input  logic [CNT_W-1:0]  ni_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              load_o,
    output logic              cmp_req_o,
    output logic              wr_valid_o,
    output logic              bcast_o,
    output logic              inc_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam logic [IDX_W-1:0] DEPTH = IDX_W'(MAX_EVENTS);

    mts_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [SLOT_W-1:0] slot_q;
    logic [IDX_W-1:0]  cnt_eff;
    logic [IDX_W-1:0]  idx_inc;
    logic              gate_open;
    logic              bc_final;
    logic              inc_final;

    assign cnt_eff   = (count_i > DEPTH) ? DEPTH : count_i;
    assign idx_inc   = idx_q + IDX_W'(1);
    assign gate_open = cmp_ack_i && cmp_ge_i;
    assign bc_final  = wr_ready_i && (slot_q == SLOT_W'(nb_i - CNT_W'(1)));
    assign inc_final = wr_ready_i && (slot_q == SLOT_W'(ni_i - CNT_W'(1)));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Index, count and slot registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            last_q <= '0;
            slot_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        idx_q  <= '0;
                        last_q <= cnt_eff;
                    end
                    slot_q <= '0;
                end
                S_WAIT: begin
                    slot_q <= '0;
                end
                S_BCAST: begin
                    if (wr_ready_i) begin
                        slot_q <= bc_final ? '0 : slot_q + SLOT_W'(1);
                    end
                end
                S_INC: begin
                    if (wr_ready_i) begin
                        slot_q <= inc_final ? '0 : slot_q + SLOT_W'(1);
                    end
                end
                S_NEXT: begin
                    idx_q <= idx_inc;
                end
                S_FETCH, S_LOAD, S_DONE: begin
                    slot_q <= '0;
                end
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = (cnt_eff == '0) ? S_DONE : S_FETCH;
                end
            end
            S_FETCH: state_d = S_LOAD;
            S_LOAD:  state_d = S_WAIT;
            S_WAIT: begin
                if (gate_open) begin
                    if (nb_i != '0)      state_d = S_BCAST;
                    else if (ni_i != '0) state_d = S_INC;
                    else                 state_d = S_NEXT;
                end
            end
            S_BCAST: begin
                if (bc_final) begin
                    state_d = (ni_i != '0) ? S_INC : S_NEXT;
                end
            end
            S_INC: begin
                if (inc_final) begin
                    state_d = S_NEXT;
                end
            end
            S_NEXT: state_d = (idx_inc == last_q) ? S_DONE : S_FETCH;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        busy_o     = 1'b1;
        done_o     = 1'b0;
        rd_en_o    = 1'b0;
        load_o     = 1'b0;
        cmp_req_o  = 1'b0;
        wr_valid_o = 1'b0;
        bcast_o    = 1'b0;
        inc_o      = 1'b0;
        unique case (state_q)
            S_IDLE:  busy_o = 1'b0;
            S_FETCH: rd_en_o = 1'b1;
            S_LOAD:  load_o = 1'b1;
            S_WAIT:  cmp_req_o = 1'b1;
            S_BCAST: begin
                wr_valid_o = 1'b1;
                bcast_o    = 1'b1;
            end
            S_INC: begin
                wr_valid_o = 1'b1;
                inc_o      = 1'b1;
            end
            S_NEXT:  busy_o = 1'b1;
            S_DONE:  done_o = 1'b1;
        endcase
    end

    assign idx_o  = idx_q;
    assign slot_o = slot_q;

endmodule

// File: rtl/mesh_tape_seq.sv
module mesh_tape_seq
    import mts_pkg::*;
#(
    parameter int  IDX_W     = 16,
    parameter int  SEM_W     = 8,
    parameter int  VAL_W     = 32,
    parameter int  BMP_W     = 16,
    parameter int  ADDR_W    = 32,
    parameter bit  FULL_TAPE = 1'b1,
    localparam int ENTRY_W   = SEM_W + VAL_W + 2 * CNT_W
                             + BC_SLOTS * (ADDR_W + BMP_W) + INC_SLOTS * ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   count_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               tbl_rd_en_o,
    output logic [IDX_W-1:0]   tbl_rd_addr_o,
    input  logic [ENTRY_W-1:0] tbl_rd_data_i,
    output logic               cmp_req_o,
    output logic [SEM_W-1:0]   cmp_sem_o,
    output logic [VAL_W-1:0]   cmp_val_o,
    input  logic               cmp_ack_i,
    input  logic               cmp_ge_i,
    output logic               wr_valid_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [VAL_W-1:0]   wr_data_o,
    input  logic               wr_ready_i
);

    localparam int MAX_EVENTS = FULL_TAPE ? FULL_DEPTH : REDUCED_DEPTH;

    logic                             load;
    logic                             bcast;
    logic                             inc;
    logic [SLOT_W-1:0]                slot;
    logic [CNT_W-1:0]                 nb;
    logic [CNT_W-1:0]                 ni;
    logic [BC_SLOTS-1:0][ADDR_W-1:0]  bc_addr;
    logic [BC_SLOTS-1:0][BMP_W-1:0]   bc_map;
    logic [INC_SLOTS-1:0][ADDR_W-1:0] inc_addr;

    mts_fsm #(
        .IDX_W      (IDX_W),
        .MAX_EVENTS (MAX_EVENTS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (count_i),
        .cmp_ack_i  (cmp_ack_i),
        .cmp_ge_i   (cmp_ge_i),
        .wr_ready_i (wr_ready_i),
        .nb_i       (nb),
        .ni_i       (ni),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .rd_en_o    (tbl_rd_en_o),
        .idx_o      (tbl_rd_addr_o),
        .load_o     (load),
        .cmp_req_o  (cmp_req_o),
        .wr_valid_o (wr_valid_o),
        .bcast_o    (bcast),
        .inc_o      (inc),
        .slot_o     (slot)
    );

    mts_entry_reg #(
        .SEM_W   (SEM_W),
        .VAL_W   (VAL_W),
        .BMP_W   (BMP_W),
        .ADDR_W  (ADDR_W),
        .ENTRY_W (ENTRY_W)
    ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .entry_i    (tbl_rd_data_i),
        .sem_o      (cmp_sem_o),
        .wait_o     (cmp_val_o),
        .nb_o       (nb),
        .ni_o       (ni),
        .bc_addr_o  (bc_addr),
        .bc_map_o   (bc_map),
        .inc_addr_o (inc_addr)
    );

    mts_write_mux #(
        .VAL_W  (VAL_W),
        .BMP_W  (BMP_W),
        .ADDR_W (ADDR_W)
    ) u_wmux (
        .bcast_i    (bcast),
        .inc_i      (inc),
        .slot_i     (slot),
        .bc_addr_i  (bc_addr),
        .bc_map_i   (bc_map),
        .inc_addr_i (inc_addr),
        .addr_o     (wr_addr_o),
        .data_o     (wr_data_o)
    );

endmodule

// File: rtl/mts_checker.sv
module mts_checker #(
    parameter int IDX_W      = 16,
    parameter int SEM_W      = 8,
    parameter int VAL_W      = 32,
    parameter int ADDR_W     = 32,
    parameter int MAX_EVENTS = 108
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              tbl_rd_en_o,
    input logic [IDX_W-1:0]  tbl_rd_addr_o,
    input logic              cmp_req_o,
    input logic [SEM_W-1:0]  cmp_sem_o,
    input logic [VAL_W-1:0]  cmp_val_o,
    input logic              cmp_ack_i,
    input logic              cmp_ge_i,
    input logic              wr_valid_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [VAL_W-1:0]  wr_data_o,
    input logic              wr_ready_i
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!tbl_rd_en_o && !cmp_req_o && !wr_valid_o && !done_o)); // R1

    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tbl_rd_en_o, cmp_req_o, wr_valid_o, done_o})); // R2

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en_o |-> (int'(tbl_rd_addr_o) < MAX_EVENTS)); // R8

    AST_WAIT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req_o && cmp_ack_i && !cmp_ge_i) |=> (!wr_valid_o && cmp_req_o)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R10

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req_o && !cmp_ack_i) |=> (cmp_req_o && $stable(cmp_sem_o) && $stable(cmp_val_o))); // R10

endmodule

bind mesh_tape_seq mts_checker #(
    .IDX_W      (IDX_W),
    .SEM_W      (SEM_W),
    .VAL_W      (VAL_W),
    .ADDR_W     (ADDR_W),
    .MAX_EVENTS (MAX_EVENTS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .tbl_rd_en_o   (tbl_rd_en_o),
    .tbl_rd_addr_o (tbl_rd_addr_o),
    .cmp_req_o     (cmp_req_o),
    .cmp_sem_o     (cmp_sem_o),
    .cmp_val_o     (cmp_val_o),
    .cmp_ack_i     (cmp_ack_i),
    .cmp_ge_i      (cmp_ge_i),
    .wr_valid_o    (wr_valid_o),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .wr_ready_i    (wr_ready_i)
);

// File: tb/mesh_tape_seq_bench.sv
`timescale 1ns/1ps
module mesh_tape_seq_bench;

    localparam int IDX_W   = 16;
    localparam int SEM_W   = 8;
    localparam int VAL_W   = 32;
    localparam int BMP_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int ENTRY_W = SEM_W + VAL_W + 4 + 2 * (ADDR_W + BMP_W) + 3 * ADDR_W;
    localparam int DEPTH   = 50;
    localparam int TAPE    = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [IDX_W-1:0]   count = '0;
    logic               busy, done;
    logic               rd_en;
    logic [IDX_W-1:0]   rd_addr;
    logic [ENTRY_W-1:0] rd_data = '0;
    logic               cmp_req;
    logic [SEM_W-1:0]   cmp_sem;
    logic [VAL_W-1:0]   cmp_val;
    logic               cmp_ack = 1'b0;
    logic               cmp_ge = 1'b0;
    logic               wr_valid;
    logic [ADDR_W-1:0]  wr_addr;
    logic [VAL_W-1:0]   wr_data;
    logic               wr_ready = 1'b1;
    logic               stall = 1'b0;

    always #10 clk = ~clk;

    mesh_tape_seq #(
        .IDX_W(IDX_W), .SEM_W(SEM_W), .VAL_W(VAL_W), .BMP_W(BMP_W),
        .ADDR_W(ADDR_W), .FULL_TAPE(1'b0)
    ) u_mesh_tape_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(count),
        .busy_o(busy), .done_o(done),
        .tbl_rd_en_o(rd_en), .tbl_rd_addr_o(rd_addr), .tbl_rd_data_i(rd_data),
        .cmp_req_o(cmp_req), .cmp_sem_o(cmp_sem), .cmp_val_o(cmp_val),
        .cmp_ack_i(cmp_ack), .cmp_ge_i(cmp_ge),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_ready_i(wr_ready)
    );

    // Environment models
    logic [ENTRY_W-1:0] tape    [TAPE];
    logic [VAL_W-1:0]   sem_mem [256];
    logic [SEM_W-1:0]   e_sem   [TAPE];
    logic [VAL_W-1:0]   e_wait  [TAPE];
    int                 e_nb    [TAPE];
    int                 e_ni    [TAPE];

    int checks = 0;
    int fails  = 0;
    int rd_n = 0, wr_n = 0, done_cnt = 0, cmp_n = 0;
    logic [IDX_W-1:0]  rd_log    [128];
    int                rd_wr_at  [128];
    logic [ADDR_W-1:0] wa_log    [512];
    logic [VAL_W-1:0]  wd_log    [512];
    logic [SEM_W-1:0]  cs_log    [128];
    logic [VAL_W-1:0]  cv_log    [128];

    always @(posedge clk) begin
        if (rd_en) rd_data <= (int'(rd_addr) < TAPE) ? tape[rd_addr] : '0;
        cmp_ack <= cmp_req && !cmp_ack;
        cmp_ge  <= (sem_mem[cmp_sem] >= cmp_val);
        wr_ready <= stall ? ~wr_ready : 1'b1;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (rd_en && rd_n < 128) begin
                rd_log[rd_n] = rd_addr; rd_wr_at[rd_n] = wr_n; rd_n++;
            end
            if (wr_valid && wr_ready && wr_n < 512) begin
                wa_log[wr_n] = wr_addr; wd_log[wr_n] = wr_data; wr_n++;
            end
            if (cmp_req && cmp_ack && cmp_ge && cmp_n < 128) begin
                cs_log[cmp_n] = cmp_sem; cv_log[cmp_n] = cmp_val; cmp_n++;
            end
            if (done) done_cnt++;
        end
    end

    function automatic logic [ADDR_W-1:0] ba(int i, int s); return 32'h1000_0000 + i * 16 + s; endfunction
    function automatic logic [BMP_W-1:0]  bm(int i, int s); return 16'hA000 + 16'(i * 4 + s); endfunction
    function automatic logic [ADDR_W-1:0] ia(int i, int s); return 32'h2000_0000 + i * 16 + s; endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Entry layout per R2, least significant field first.
    task automatic set_ev(input int i, input int sem, input int wv, input int nb, input int ni);
        e_sem[i] = SEM_W'(sem); e_wait[i] = VAL_W'(wv); e_nb[i] = nb; e_ni[i] = ni;
        tape[i] = {ia(i,2), ia(i,1), ia(i,0), bm(i,1), bm(i,0), ba(i,1), ba(i,0),
                   2'(ni), 2'(nb), VAL_W'(wv), SEM_W'(sem)};
    endtask

    task automatic clear_logs();
        rd_n = 0; wr_n = 0; cmp_n = 0;
    endtask

    task automatic kick(input int cnt);
        @(negedge clk);
        clear_logs();
        count = IDX_W'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0, input string req);
        int t = 0;
        while (done_cnt == d0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(done_cnt == d0 + 1, req, done_cnt - d0, 1);
        chk(busy == 1'b0, req, busy, 0);
    endtask

    // Compares logs against writes derived from events 0..n-1 (R2, R4, R5, R6).
    task automatic check_tape(input int n, input string tag);
        int k = 0;
        chk(rd_n == n, {tag, " R2 read count"}, rd_n, n);
        for (int i = 0; i < n && i < rd_n; i++) begin
            chk(rd_log[i] == IDX_W'(i), {tag, " R2 read order"}, rd_log[i], i);
            chk(rd_wr_at[i] == k, {tag, " R2 writes before next read"}, rd_wr_at[i], k);
            for (int s = 0; s < ((e_nb[i] > 2) ? 2 : e_nb[i]); s++) begin
                chk(wa_log[k] == ba(i,s), {tag, " R4 doorbell addr"}, wa_log[k], ba(i,s));
                chk(wd_log[k] == {bm(i,s), 16'h0100}, {tag, " R4 doorbell data"}, wd_log[k], {bm(i,s), 16'h0100});
                k++;
            end
            for (int s = 0; s < e_ni[i]; s++) begin
                chk(wa_log[k] == ia(i,s), {tag, " R5 inc addr"}, wa_log[k], ia(i,s));
                chk(wd_log[k] == 32'd1, {tag, " R5 inc data"}, wd_log[k], 1);
                k++;
            end
        end
        chk(wr_n == k, {tag, " R6 total writes"}, wr_n, k);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        chk(rd_en == 1'b0 && cmp_req == 1'b0 && wr_valid == 1'b0, "R1 requests", {rd_en, cmp_req, wr_valid}, 0);
    endtask

    task automatic t_basic(input bit stl, input string tag);
        int d0;
        set_ev(0, 1, 4, 2, 3);
        set_ev(1, 2, 0, 1, 1);
        set_ev(2, 3, 9, 0, 2);
        set_ev(3, 4, 2, 3, 0);
        set_ev(4, 5, 1, 0, 0);
        sem_mem[1] = 10; sem_mem[2] = 0; sem_mem[3] = 9; sem_mem[4] = 5; sem_mem[5] = 1;
        @(negedge clk);
        stall = stl;
        d0 = done_cnt;
        kick(5);
        wait_done(d0, {tag, " R7 done"});
        check_tape(5, tag);
        chk(cmp_n == 5 && cs_log[2] == 8'd3 && cv_log[2] == 32'd9, {tag, " R3 compare fields"}, {cs_log[2], cv_log[2]}, {8'd3, 32'd9});
        stall = 1'b0;
    endtask

    task automatic t_wait_gate();
        int d0;
        set_ev(0, 7, 7, 1, 1);
        sem_mem[7] = 3;
        d0 = done_cnt;
        kick(1);
        repeat (40) @(negedge clk);
        chk(wr_n == 0, "R3 no write while below wait value", wr_n, 0);
        chk(busy == 1'b1, "R3 still waiting", busy, 1);
        sem_mem[7] = 7;
        wait_done(d0, "R3 done after release");
        check_tape(1, "R3 gated");
    endtask

    task automatic t_zero_count();
        int d0 = done_cnt;
        kick(0);
        wait_done(d0, "R7 zero count done");
        chk(rd_n == 0 && wr_n == 0, "R7 zero count no reads", rd_n + wr_n, 0);
    endtask

    task automatic t_clamp();
        int d0;
        for (int i = 0; i < 60; i++) set_ev(i, 0, 0, 0, 0);
        sem_mem[0] = 0;
        d0 = done_cnt;
        kick(60);
        wait_done(d0, "R8 clamped done");
        chk(rd_n == DEPTH, "R8 reads clamped", rd_n, DEPTH);
        chk(rd_log[DEPTH-1] == IDX_W'(DEPTH - 1), "R8 last index", rd_log[DEPTH-1], DEPTH - 1);
        chk(wr_n == 0, "R6 empty events no writes", wr_n, 0);
    endtask

    task automatic t_start_busy();
        int d0;
        for (int i = 0; i < 4; i++) set_ev(i, 1, 1, 1, 1);
        sem_mem[1] = 1;
        d0 = done_cnt;
        kick(4);
        repeat (6) @(negedge clk);
        count = 16'd2; start = 1'b1;
        @(negedge clk);
        count = 16'd9;
        @(negedge clk);
        start = 1'b0;
        wait_done(d0, "R9 single done");
        check_tape(4, "R9 unchanged run");
        repeat (10) @(negedge clk);
        chk(rd_n == 4 && busy == 1'b0, "R9 no restart", rd_n, 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) sem_mem[i] = '0;
        for (int i = 0; i < TAPE; i++) set_ev(i, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic(1'b0, "plain");
        t_basic(1'b1, "R10 stalled");
        t_wait_gate();
        t_zero_count();
        t_clamp();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule